// File: doc/BRIEF.md
# Row write latch with commit sequencer and programming timer

This block stands between a serial memory's bus protocol engine and its storage array. When a write command opens, the engine hands it the target address. The block keeps the upper address bits as the row and the low bits as a column pointer. Each data byte the engine then accepts is parked in a row-wide latch at the pointer's column. The pointer wraps inside the row, so a long command writes over its own earlier bytes instead of spilling into the next row.

The parked bytes reach the array only if the engine reports a STOP that fell exactly after an acknowledge slot. Any other termination, reported as an abort, throws the command away. A proper termination starts a commit scan. The scan walks the row's columns in order and emits one array write strobe for each column that the command touched. A programming window of a parameterised number of clock cycles follows. The busy output covers both the scan and the window, and while it is high every request from the engine is ignored. Write protection is sampled when the address is loaded: a protected command latches nothing and programs nothing.

Top module: `pgwr_commit`

## Requirements
- R1: With busy low, a load pulse takes row = addr_i[ADDR_W-1:4] and start column = addr_i[3:0]. It discards any bytes parked by an earlier, unfinished command and samples wprot_i for the new command.
- R2: Each data strobe of an open, unprotected command stores data_i at the current column. The column then advances modulo 16 and the row is unchanged, so a seventeenth byte replaces the first byte's column.
- R3: A stop pulse with no abort in the same cycle, on an open command holding at least one byte, raises busy at the next clock edge. The commit strobes arr_we_o only while busy is high, in strictly ascending column order, with arr_addr_o = {row, column} and arr_data_o = the last byte parked at that column.
- R4: Columns the command did not write get no strobe, so their array contents keep their earlier values.
- R5: Busy stays high for exactly 16 + BUSY_CYCLES consecutive cycles per commit and then falls. A load in the last busy cycle is ignored; a load in the following cycle is accepted.
- R6: An abort closes the open command. A later stop, or a stop arriving in the same cycle as the abort, produces no strobe and no busy.
- R7: A command loaded while wprot_i is high latches no bytes and programs nothing. Raising wprot_i after the load does not block the command.
- R8: While busy is high, loads, data strobes, stops and aborts have no effect. After a commit the command is closed, so a stop without a new load does nothing.
- R9: A stop on a command that holds no bytes starts no commit.
- R10: After reset, busy and arr_we_o are low.
- R11: Data strobes and stops that arrive before any load are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_addr_i | input | 1 | Opens a command at addr_i |
| addr_i | input | ADDR_W | Byte address of the first data byte |
| data_stb_i | input | 1 | One accepted data byte on data_i |
| data_i | input | DATA_W | Data byte |
| stop_ack_i | input | 1 | STOP seen directly after an acknowledge slot |
| abort_i | input | 1 | Command ended any other way |
| wprot_i | input | 1 | Write protection level |
| busy_o | output | 1 | Commit scan or programming window in progress |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_data_o | output | DATA_W | Array byte data |

## Verification
The end of the programming window and a new address load can land in the same cycle. The bench counts its drive cycles from the stop pulse and places a load in the last busy cycle, which must be ignored. It then repeats the sequence with the load one cycle later, which must commit. A stop and an abort asserted together are judged by the absence of busy and strobes. A sweep of every start column against command lengths of 1 to 18 bytes compares the strobe count, the busy length, the column order and the whole array model with values computed in the bench.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } pgwr_state_e;
endpackage

// File: rtl/pgwr_row_latch.sv
// Row-wide byte latch with a per-column written flag.
module pgwr_row_latch #(
  parameter int ROW_BYTES = 16,
  parameter int DATA_W    = 8,
  localparam int COL_W    = $clog2(ROW_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [COL_W-1:0]  wr_col_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              any_o
);
  logic [ROW_BYTES-1:0] mask_w;
  logic [DATA_W-1:0]    data_w [ROW_BYTES];

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slot
    logic              hit;
    logic              m_q, m_d;
    logic [DATA_W-1:0] d_q;

    assign hit = wr_i && (wr_col_i == COL_W'(g));

    always_comb begin
      m_d = m_q;
      if (clr_i)    m_d = 1'b0;
      else if (hit) m_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= 1'b0;
      else        m_q <= m_d;
    end

    // data storage needs no reset: only read where the flag is set
    always_ff @(posedge clk) begin
      if (hit) d_q <= wr_data_i;
    end

    assign mask_w[g] = m_q;
    assign data_w[g] = d_q;
  end

  assign rd_valid_o = mask_w[rd_col_i];
  assign rd_data_o  = data_w[rd_col_i];
  assign any_o      = |mask_w;
endmodule

// File: rtl/pgwr_busy_timer.sv
// Self-timed programming window, counted in clock cycles.
module pgwr_busy_timer #(
  parameter int BUSY_CYCLES = 500000,
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start_i) begin
      cnt_d = CNT_W'(BUSY_CYCLES - 1);
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/pgwr_ctrl.sv
// Command tracking, column pointer and commit sequencing.
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int ROW_BYTES = 16,
  localparam int COL_W    = $clog2(ROW_BYTES),
  localparam int ROW_W    = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stb_i,
  input  logic              stop_i,
  input  logic              abort_i,
  input  logic              wprot_i,
  input  logic              any_i,
  input  logic              tmr_done_i,
  output logic              latch_clr_o,
  output logic              latch_wr_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [COL_W-1:0]  scan_col_o,
  output logic              scan_act_o,
  output logic              tmr_start_o,
  output logic              busy_o,
  output logic [ROW_W-1:0]  row_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_BYTES - 1);

  pgwr_state_e      state_q, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [COL_W-1:0] scan_q, scan_d;
  logic             open_q, open_d;
  logic             wp_q, wp_d;

  always_comb begin
    state_d     = state_q;
    row_d       = row_q;
    col_d       = col_q;
    scan_d      = scan_q;
    open_d      = open_q;
    wp_d        = wp_q;
    latch_clr_o = 1'b0;
    latch_wr_o  = 1'b0;
    tmr_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load_i) begin
          row_d       = addr_i[ADDR_W-1:COL_W];
          col_d       = addr_i[COL_W-1:0];
          open_d      = 1'b1;
          wp_d        = wprot_i;
          latch_clr_o = 1'b1;
        end else if (open_q) begin
          if (abort_i) begin
            open_d = 1'b0;
          end else if (stop_i) begin
            open_d = 1'b0;
            if (any_i && !wp_q) begin
              state_d = ST_SCAN;
              scan_d  = '0;
            end
          end else if (stb_i && !wp_q) begin
            latch_wr_o = 1'b1;
            col_d      = (col_q == COL_LAST) ? '0 : col_q + 1'b1;
          end
        end
      end
      ST_SCAN: begin
        if (scan_q == COL_LAST) begin
          state_d     = ST_WAIT;
          tmr_start_o = 1'b1;
        end else begin
          scan_d = scan_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (tmr_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      scan_q  <= '0;
      open_q  <= 1'b0;
      wp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
      scan_q  <= scan_d;
      open_q  <= open_d;
      wp_q    <= wp_d;
    end
  end

  assign wr_col_o   = col_q;
  assign scan_col_o = scan_q;
  assign scan_act_o = (state_q == ST_SCAN);
  assign busy_o     = (state_q != ST_IDLE);
  assign row_o      = row_q;
endmodule

// File: rtl/pgwr_commit.sv
// Page write buffer: row latch, commit scan and programming timer.
module pgwr_commit #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int ROW_BYTES   = 16,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_stb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_ack_i,
  input  logic              abort_i,
  input  logic              wprot_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  localparam int COL_W = $clog2(ROW_BYTES);
  localparam int ROW_W = ADDR_W - COL_W;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             latch_clr, latch_wr, any_w, rd_valid;
  logic             scan_act, tmr_start, tmr_done;
  logic [COL_W-1:0] wr_col, scan_col;
  logic [ROW_W-1:0] row_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pgwr_ctrl #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .load_i(load_addr_i), .addr_i(addr_i), .stb_i(data_stb_i),
    .stop_i(stop_ack_i), .abort_i(abort_i), .wprot_i(wprot_i),
    .any_i(any_w), .tmr_done_i(tmr_done),
    .latch_clr_o(latch_clr), .latch_wr_o(latch_wr), .wr_col_o(wr_col),
    .scan_col_o(scan_col), .scan_act_o(scan_act), .tmr_start_o(tmr_start),
    .busy_o(busy_o), .row_o(row_w)
  );

  pgwr_row_latch #(.ROW_BYTES(ROW_BYTES), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_core_n),
    .clr_i(latch_clr), .wr_i(latch_wr), .wr_col_i(wr_col), .wr_data_i(data_i),
    .rd_col_i(scan_col), .rd_valid_o(rd_valid), .rd_data_o(arr_data_o),
    .any_o(any_w)
  );

  pgwr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_core_n), .start_i(tmr_start), .done_o(tmr_done)
  );

  assign arr_we_o   = scan_act && rd_valid;
  assign arr_addr_o = {row_w, scan_col};
endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
  parameter int ADDR_W      = 11,
  parameter int ROW_BYTES   = 16,
  parameter int BUSY_CYCLES = 500000,
  localparam int COL_W      = $clog2(ROW_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_ack_i,
  input logic              abort_i,
  input logic              busy_o,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  assert_we_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(stop_ack_i) && !$past(abort_i)));

  assert_col_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |->
      (arr_addr_o[COL_W-1:0] > $past(arr_addr_o[COL_W-1:0])));

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run == ROW_BYTES + BUSY_CYCLES));

  assert_abort_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !busy_o) |=> !busy_o);
endmodule

bind pgwr_commit pgwr_commit_chk #(
  .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_ack_i(stop_ack_i), .abort_i(abort_i),
  .busy_o(busy_o), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o)
);

// File: tb/pgwr_commit_tb.sv
module pgwr_commit_tb;
  localparam int AW = 6, DW = 8, RB = 16, BC = 20, DEPTH = 64;
  localparam int WIN = RB + BC;

  logic clk = 1'b0;
  logic rst_n;
  logic load_addr, data_stb, stop_ack, abort_c, wprot;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int n_tests = 0, n_fail = 0;
  int we_cnt = 0, busy_cnt = 0, order_err = 0, last_col = -1;
  int b_we, b_busy, b_ord;
  logic [7:0] mem_seen [DEPTH] = '{default: 8'hFF};
  logic [7:0] exp_mem  [DEPTH] = '{default: 8'hFF};

  always #2 clk = ~clk;

  pgwr_commit #(.ADDR_W(AW), .DATA_W(DW), .ROW_BYTES(RB), .BUSY_CYCLES(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_addr_i(load_addr), .addr_i(addr),
    .data_stb_i(data_stb), .data_i(data), .stop_ack_i(stop_ack),
    .abort_i(abort_c), .wprot_i(wprot), .busy_o(busy), .arr_we_o(arr_we),
    .arr_addr_o(arr_addr), .arr_data_o(arr_data)
  );

  // output monitor: sole writer of the counters and of mem_seen
  always @(negedge clk) begin
    if (busy) busy_cnt++;
    else      last_col = -1;
    if (arr_we) begin
      mem_seen[arr_addr] = arr_data;
      we_cnt++;
      if (int'(arr_addr[3:0]) <= last_col) order_err++;
      last_col = int'(arr_addr[3:0]);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic l, input int a, input logic b, input int d,
                       input logic s, input logic ab);
    @(negedge clk);
    load_addr = l; addr = AW'(a); data_stb = b; data = DW'(d);
    stop_ack = s; abort_c = ab;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic snap();
    @(posedge clk);
    b_we = we_cnt; b_busy = busy_cnt; b_ord = order_err;
  endtask

  task automatic end_checks(input string req, input int exp_we, input int exp_busy);
    @(posedge clk);
    check(req, "strobe count", we_cnt - b_we, exp_we);
    check(req, "busy cycles", busy_cnt - b_busy, exp_busy);
    check(req, "column order errors", order_err - b_ord, 0);
    begin
      int mism = 0;
      for (int i = 0; i < DEPTH; i++) if (mem_seen[i] !== exp_mem[i]) mism++;
      check(req, "array mismatches", mism, 0);
    end
  endtask

  function automatic int dval(input int seed, input int i);
    return (seed * 37 + i * 11 + 5) & 8'hFF;
  endfunction

  task automatic write_cmd(input int row, input int col, input int n, input int seed,
                           input logic wp_load, input logic wp_late);
    drive(1, row * RB + col, 0, 0, 0, 0);
    wprot = wp_load;
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 1, dval(seed, i), 0, 0);
      if (i == 0) wprot = wp_late;
    end
    drive(0, 0, 0, 0, 1, 0);
    idle(WIN + 4);
    wprot = 1'b0;
    if (!wp_load && n > 0)
      for (int i = 0; i < n; i++) exp_mem[row * RB + (col + i) % RB] = DW'(dval(seed, i));
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_addr = 0; addr = '0; data_stb = 0; data = '0;
    stop_ack = 0; abort_c = 0; wprot = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R10: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10", "busy after reset", int'(busy), 0);
      check("R10", "strobe after reset", int'(arr_we), 0);
    end

    // R11: strobes and stop without a load
    snap();
    drive(0, 0, 1, 8'h12, 0, 0); drive(0, 0, 0, 0, 1, 0); idle(WIN);
    end_checks("R11", 0, 0);

    // R2 R3 R4 R5: sweep start column against length 1..18
    for (int sc = 0; sc < RB; sc++)
      for (int n = 1; n <= 18; n++) begin
        snap();
        write_cmd((sc * 3 + n) % 4, sc, n, sc * 19 + n, 1'b0, 1'b0);
        end_checks("R2", (n > RB) ? RB : n, WIN);
      end

    // R9: address only, then stop
    snap();
    drive(1, 2 * RB + 5, 0, 0, 0, 0); drive(0, 0, 0, 0, 1, 0); idle(WIN);
    end_checks("R9", 0, 0);

    // R6: abort then stop; abort together with stop
    snap();
    drive(1, 1 * RB + 3, 0, 0, 0, 0); drive(0, 0, 1, 8'hA5, 0, 0);
    drive(0, 0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1, 0); idle(WIN);
    drive(1, 1 * RB + 3, 0, 0, 0, 0); drive(0, 0, 1, 8'h5A, 0, 0);
    drive(0, 0, 0, 0, 1, 1); drive(0, 0, 0, 0, 1, 0); idle(WIN);
    end_checks("R6", 0, 0);

    // R7: protected at load; protection raised only after load
    snap();
    write_cmd(3, 7, 4, 201, 1'b1, 1'b1);
    end_checks("R7", 0, 0);
    snap();
    write_cmd(3, 7, 4, 202, 1'b0, 1'b1);
    end_checks("R7", 4, WIN);

    // R1: second load before the stop restarts the command
    snap();
    drive(1, 0 * RB + 3, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 8'h30 + i, 0, 0);
    drive(1, 2 * RB + 9, 0, 0, 0, 0);
    drive(0, 0, 1, 8'hC1, 0, 0); drive(0, 0, 1, 8'hC2, 0, 0);
    drive(0, 0, 0, 0, 1, 0); idle(WIN + 4);
    exp_mem[2 * RB + 9] = 8'hC1; exp_mem[2 * RB + 10] = 8'hC2;
    end_checks("R1", 2, WIN);

    // R8: traffic during busy is ignored; stop after commit does nothing
    snap();
    drive(1, 1 * RB + 14, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 8'h70 + i, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    drive(1, 3 * RB + 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 8'hE0 + i, 0, 0);
    drive(0, 0, 0, 0, 1, 0); drive(0, 0, 0, 0, 0, 1);
    idle(WIN);
    drive(0, 0, 0, 0, 1, 0); idle(WIN);
    exp_mem[1 * RB + 14] = 8'h70; exp_mem[1 * RB + 15] = 8'h71; exp_mem[1 * RB + 0] = 8'h72;
    end_checks("R8", 3, WIN);

    // R5: load in the last busy cycle is ignored
    snap();
    drive(1, 0 * RB + 6, 0, 0, 0, 0); drive(0, 0, 1, 8'h4B, 0, 0);
    drive(0, 0, 0, 0, 1, 0); idle(WIN - 1);
    drive(1, 2 * RB + 1, 0, 0, 0, 0); drive(0, 0, 1, 8'h99, 0, 0);
    drive(0, 0, 0, 0, 1, 0); idle(WIN + 4);
    exp_mem[0 * RB + 6] = 8'h4B;
    end_checks("R5", 1, WIN);

    // R5: load one cycle after busy falls is accepted
    snap();
    drive(1, 0 * RB + 8, 0, 0, 0, 0); drive(0, 0, 1, 8'h4C, 0, 0);
    drive(0, 0, 0, 0, 1, 0); idle(WIN);
    drive(1, 2 * RB + 1, 0, 0, 0, 0); drive(0, 0, 1, 8'h9A, 0, 0);
    drive(0, 0, 0, 0, 1, 0); idle(WIN + 4);
    exp_mem[0 * RB + 8] = 8'h4C; exp_mem[2 * RB + 1] = 8'h9A;
    end_checks("R5", 2, 2 * WIN);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule